// File: doc/BRIEF.md
# Sixty-Four-Bit Tick Timer with One Compare Channel

The block counts clock cycles in a 64-bit register that starts at zero on reset and then never stops. Software sees the count as two 32-bit words on a small register bus. The bus has an address, a write strobe, write data and combinational read data. The two words are not captured together. To get a consistent 64-bit value, software reads the upper word, then the lower word, then the upper word again, and retries if the two upper reads differ.

One compare channel watches only the lower 32 bits of the count. Software sets a deadline by writing "present low word plus delta" to the compare register, with wrap-around modulo 2^32, and then turns on compare enable. When the channel is enabled and the low word equals the compare value, a sticky match flag is set. The interrupt output is high while the flag and the enable are both set. The interrupt handler can drop the interrupt with a single control write that clears the flag and disables the channel.

The channel is a four-state machine, built from the enable bit and the flag bit:
- CH_IDLE: disabled, no flag.
- CH_ARMED: enabled, waiting for a match.
- CH_FIRED: enabled, flag set, interrupt high.
- CH_HELD: disabled, flag still set, interrupt low.

Its transitions are:
- arm: IDLE to ARMED, and HELD to FIRED.
- disarm: ARMED to IDLE, and FIRED to HELD.
- hit: ARMED to FIRED, or ARMED to HELD when a disable write lands on the same edge.
- clear: FIRED to ARMED, and HELD to IDLE.
- clear-and-disarm: FIRED to IDLE.

A hit on the same edge as a clear keeps the flag set.

Top module: `sys_tick_timer`

## Requirements
- R1: While reset is asserted, the count, the compare register, compare enable and the match flag are all zero, every register reads 0 and `irq` is 0.
- R2: The 64-bit count rises by exactly one per clock. The low word reads at byte offset 0x4 and the high word at 0x8, both from the live counter with no latching. The high word changes only on the edge where the low word passes from 0xFFFF_FFFF to 0.
- R3: The compare register at offset 0xC is loaded by a bus write and reads back the written value.
- R4: The control word at offset 0x0 has compare enable at bit 4 (read/write) and the match flag at bit 0. All other control bits read 0 and ignore writes. Any address other than 0x0, 0x4, 0x8 or 0xC reads 0, and writes to it are ignored.
- R5: On a clock edge where enable is 1 and the low word equals the compare value, the flag becomes 1, visible from the next cycle. It then stays 1 until software clears it.
- R6: While enable is 0, a low word equal to the compare value does not set the flag.
- R7: Writing 1 to control bit 0 clears the flag. Writing 0 there leaves the flag unchanged. The same write also loads bit 4, so writing 0x01 clears the flag and disables the channel in one access.
- R8: When a clear write and a match fall on the same edge, the flag stays 1.
- R9: `irq` is 1 exactly when the flag is 1 and enable is 1. A set flag with enable 0 keeps `irq` low, and enable returning to 1 raises `irq` again.
- R10: Writes to offsets 0x4 and 0x8 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, flag AND enable |

## Verification
The compare is tried with a deadline some cycles ahead while enabled, and the bench expects the flag on the exact cycle after the low word equals the compare value. This separates a correct match from an early or late one. The same deadline with the channel disabled separates the gated match from an ungated one. A clear write timed to land on the match edge shows which of the two wins. Writes of all-ones and all-zero patterns to the control word, and writes to the counter offsets, show that only the two defined control bits and the compare register can be changed.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int FLAG_POS = 0;
    localparam int ENA_POS  = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CMP    = 4'hC;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_FIRED = 2'd2,
        CH_HELD  = 2'd3
    } ch_state_e;

endpackage

// File: rtl/tick_counter.sv
module tick_counter
    import sys_tick_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi
);
    localparam int CW = 2 * W;
    localparam logic [CW-1:0] STEP = CW'(1);
    localparam logic [W-1:0]  ONE  = W'(1);
    localparam logic [W-1:0]  TOP  = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + STEP;
    end

    assign cnt_lo = cnt_q[W-1:0];
    assign cnt_hi = cnt_q[CW-1:W];

    // R2: high word carries only out of a wrapping low word
    a_r2_hi_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo == TOP) |=> (cnt_hi == $past(cnt_hi) + ONE));
    a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo != TOP) |=> $stable(cnt_hi));
    a_r2_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_lo == $past(cnt_lo) + ONE));

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import sys_tick_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_lo,
    input  logic [W-1:0] cmp_val,
    input  logic         ctrl_wr,
    input  logic         wr_clear,
    input  logic         wr_enable,
    output logic         ch_en,
    output logic         ch_flag
);
    ch_state_e state_q, state_d;
    logic      hit;
    logic      clr;

    function automatic ch_state_e pack_state(input logic en, input logic flag);
        unique case ({en, flag})
            2'b00:   return CH_IDLE;
            2'b10:   return CH_ARMED;
            2'b11:   return CH_FIRED;
            default: return CH_HELD;
        endcase
    endfunction

    assign hit = ch_en && (cnt_lo == cmp_val);
    assign clr = ctrl_wr && wr_clear;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctrl_wr && wr_enable) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                state_d = pack_state(ctrl_wr ? wr_enable : 1'b1, hit);
            end
            CH_FIRED: begin
                state_d = pack_state(ctrl_wr ? wr_enable : 1'b1, hit || !clr);
            end
            CH_HELD: begin
                state_d = pack_state(ctrl_wr ? wr_enable : 1'b0, !clr);
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_IDLE:  begin ch_en = 1'b0; ch_flag = 1'b0; end
            CH_ARMED: begin ch_en = 1'b1; ch_flag = 1'b0; end
            CH_FIRED: begin ch_en = 1'b1; ch_flag = 1'b1; end
            CH_HELD:  begin ch_en = 1'b0; ch_flag = 1'b1; end
        endcase
    end

    a_r5_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && (cnt_lo == cmp_val)) |=> ch_flag);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag && !(ctrl_wr && wr_clear)) |=> ch_flag);
    a_r6_no_hit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en && !ch_flag) |=> !ch_flag);

endmodule

// File: rtl/reg_decode.sv
module reg_decode
    import sys_tick_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      cnt_lo,
    input  logic [W-1:0]      cnt_hi,
    input  logic              ch_en,
    input  logic              ch_flag,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      cmp_val,
    output logic              ctrl_wr,
    output logic              wr_clear,
    output logic              wr_enable
);
    logic cmp_wr;

    assign ctrl_wr   = wr_en && (addr == OFS_CTRL);
    assign cmp_wr    = wr_en && (addr == OFS_CMP);
    assign wr_clear  = wr_data[FLAG_POS];
    assign wr_enable = wr_data[ENA_POS];

    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (cmp_wr) cmp_val <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFS_CTRL: begin
                rd_data[FLAG_POS] = ch_flag;
                rd_data[ENA_POS]  = ch_en;
            end
            OFS_CNT_LO: rd_data = cnt_lo;
            OFS_CNT_HI: rd_data = cnt_hi;
            OFS_CMP:    rd_data = cmp_val;
            default:    rd_data = '0;
        endcase
    end

    a_r3_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_CMP)) |=> (cmp_val == $past(wr_data)));

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import sys_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic [WORD_W-1:0] cnt_lo, cnt_hi, cmp_val;
    logic ch_en, ch_flag, ctrl_wr, wr_clear, wr_enable;

    tick_counter #(.W(WORD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
    );

    reg_decode #(.W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_we),
        .wr_data(bus_wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ch_en(ch_en), .ch_flag(ch_flag), .rd_data(bus_rdata),
        .cmp_val(cmp_val), .ctrl_wr(ctrl_wr), .wr_clear(wr_clear),
        .wr_enable(wr_enable)
    );

    cmp_channel #(.W(WORD_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .cmp_val(cmp_val),
        .ctrl_wr(ctrl_wr), .wr_clear(wr_clear), .wr_enable(wr_enable),
        .ch_en(ch_en), .ch_flag(ch_flag)
    );

    assign irq = ch_en && ch_flag;

    // R7 / R9: clear together with disable drops the interrupt
    a_r7_clear_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && bus_wdata[FLAG_POS] && !bus_wdata[ENA_POS])
        |=> !irq);
    // R10: bus writes to counter words do not disturb counting
    a_r10_cnt_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_HI))
        |=> (cnt_lo == $past(cnt_lo) + ONE));

endmodule

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sys_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq", {31'h0, irq}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_counter;
        logic [31:0] l, v;
        rd(4'h4, l);
        rd(4'h4, v); check("R2 lo step", v, l + 32'd1);
        rd(4'h8, v); check("R2 hi", v, 32'h0);
        wr(4'h4, 32'hFFFF_FFF0);
        wr(4'h8, 32'h1234_5678);
        rd(4'h4, v); check("R10 lo after write", v, l + 32'd5);
        rd(4'h8, v); check("R10 hi after write", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(4'hC, 32'hA5A5_1234);
        rd(4'hC, v); check("R3 cmp", v, 32'hA5A5_1234);
        wr(4'h0, 32'hFFFF_FFEE);
        rd(4'h0, v); check("R4 other bits", v, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R4 enable only", v, 32'h10);
        wr(4'h0, 32'h0);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h2, v); check("R4 unmapped", v, 32'h0);
        rd(4'hC, v); check("R4 unmapped no effect", v, 32'hA5A5_1234);
        rd(4'h0, v); check("R4 ctrl off", v, 32'h0);
    endtask

    task automatic t_match;
        logic [31:0] l, v;
        rd(4'h4, l);
        wr(4'hC, l + 32'd6);
        wr(4'h0, 32'h10);
        for (int k = 3; k <= 6; k++) begin
            rd(4'h0, v); check("R5 before match", v, 32'h10);
            check("R9 irq low", {31'h0, irq}, 32'h0);
        end
        rd(4'h0, v); check("R5 flag on time", v, 32'h11);
        check("R9 irq high", {31'h0, irq}, 32'h1);
        wr(4'h0, 32'h10);
        rd(4'h0, v); check("R7 zero keeps flag", v, 32'h11);
        rd(4'h0, v); check("R5 sticky", v, 32'h11);
        wr(4'h0, 32'h00);
        rd(4'h0, v); check("R9 held flag", v, 32'h01);
        check("R9 irq gated", {31'h0, irq}, 32'h0);
        wr(4'h0, 32'h10);
        rd(4'h0, v); check("R9 rearm", v, 32'h11);
        check("R9 irq again", {31'h0, irq}, 32'h1);
        wr(4'h0, 32'h01);
        rd(4'h0, v); check("R7 clear+disable", v, 32'h0);
        check("R7 irq dropped", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] l, v;
        rd(4'h4, l);
        wr(4'hC, l + 32'd4);
        for (int k = 2; k <= 8; k++) begin
            rd(4'h0, v); check("R6 no flag", v, 32'h0);
        end
        wr(4'h0, 32'h10);
        rd(4'h0, v); check("R6 late enable", v, 32'h10);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] l, v;
        rd(4'h4, l);
        wr(4'hC, l + 32'd6);
        wr(4'h0, 32'h10);
        for (int k = 3; k <= 6; k++) rd(4'h0, v);
        rd(4'h0, v); check("R8 setup flag", v, 32'h11);
        rd(4'h4, v); check("R8 setup lo", v, l + 32'd8);
        wr(4'hC, l + 32'd12);
        rd(4'h0, v);
        rd(4'h0, v);
        wr(4'h0, 32'h11);
        rd(4'h0, v); check("R8 match wins", v, 32'h11);
        wr(4'h0, 32'h11);
        rd(4'h0, v); check("R7 clear", v, 32'h10);
        check("R9 irq after clear", {31'h0, irq}, 32'h0);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        t_reset;
        t_counter;
        t_regs;
        t_match;
        t_disabled;
        t_collision;
        @(negedge clk);
        bus_we = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule